// File: doc/BRIEF.md
# I2C Command and Data FIFO Status Unit

This unit sits between a simple register bus and an I2C bus engine. Software writes 10-bit command words into a transmit queue, and the engine pulls them off one at a time through a valid/pop port. The engine pushes received bytes into a receive queue through a push/ready port, and software pops them by reading a data register. Both queues are `DEPTH` entries deep, 16 by default.

Software sees the following through the register bus:
- occupancy registers for both queues, each reporting the stored count minus one;
- a zero-based receive threshold;
- a status byte with full and empty flags and the bus-busy input;
- a sticky error register.

Three registered level events go to an interrupt block outside this unit: receive level reached, transmit queue empty, and transmit queue at most half full.

Register addresses on `reg_addr`:

| Address | Register | Access |
|---------|----------|--------|
| 0 | control; bit 1 is the transmit flush | read/write |
| 1 | status | read |
| 2 | transmit data | write |
| 3 | receive data | read; each read pops |
| 4 | transmit occupancy | read |
| 5 | receive occupancy | read |
| 6 | receive threshold | read/write |
| 7 | error flags; write 1 to clear | read/write |

A register read returns its value on `reg_rdata` one cycle after `reg_rd`.

Top module: `iic_fifo_status`

## Requirements
- R1: After reset, both occupancies read 0, the status byte reads 0xC0 with `bus_busy` low, `ev_tx_empty` and `ev_tx_half` are 1, and `ev_rx_level` is 0.
- R2: Transmit words written at address 2 (low 10 bits) appear on `eng_tx_word` in write order. `eng_tx_valid` is high while the queue is not empty, and each `eng_tx_pop` removes the head.
- R3: Bytes pushed by the engine are returned in order by reads of address 3. Each read pops exactly one byte.
- R4: Occupancy at address 4 (transmit) or 5 (receive) reads the stored count minus one. An empty queue also reads 0.
- R5: Status bits are: bit 2 bus busy, bit 4 transmit full, bit 5 receive full, bit 6 receive empty, bit 7 transmit empty. All other bits are 0.
- R6: `ev_rx_level` is 1 exactly while the receive count is at least threshold+1. The threshold is written at address 6. The event follows the count one cycle later.
- R7: `ev_tx_empty` is 1 while the transmit queue is empty. `ev_tx_half` is 1 while it holds DEPTH/2 or fewer entries. Both follow the count one cycle later.
- R8: While control bit 1 is set, the transmit queue is emptied and held empty.
- R9: A transmit write to a full queue is dropped. It sets error bit 0, which stays set until a 1 is written to bit 0 of address 7.
- R10: A receive data read from an empty queue returns 0 and changes no occupancy. It sets error bit 1, which stays set until a 1 is written to bit 1 of address 7.
- R11: A queue is full at exactly DEPTH entries. Then `eng_rx_ready` drops for the receive side, and an engine push to a full receive queue is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Registered read data |
| bus_busy | input | 1 | Bus busy indication from the engine |
| eng_tx_word | output | 10 | Head transmit command word |
| eng_tx_valid | output | 1 | Transmit queue not empty |
| eng_tx_pop | input | 1 | Engine takes the head word |
| eng_rx_byte | input | 8 | Received byte from the engine |
| eng_rx_push | input | 1 | Engine stores a byte |
| eng_rx_ready | output | 1 | Receive queue has room |
| ev_rx_level | output | 1 | Receive threshold reached |
| ev_tx_empty | output | 1 | Transmit queue empty |
| ev_tx_half | output | 1 | Transmit queue half empty or less |

## Verification
A corrupted pointer or count appears within one register read. The occupancy value, the status flags or the popped data differ from the scoreboard model on the next access. Event faults appear two cycles after the stimulus that moved the count.

An ordering fault in either queue appears as a scoreboard mismatch on the first word out of place. A lost or wrongly set sticky flag appears on the next read of the error register.

// File: rtl/iic_fs_pkg.sv
package iic_fs_pkg;
  localparam int REG_AW = 3;

  localparam logic [REG_AW-1:0] A_CTRL   = 3'd0;
  localparam logic [REG_AW-1:0] A_STATUS = 3'd1;
  localparam logic [REG_AW-1:0] A_TXDATA = 3'd2;
  localparam logic [REG_AW-1:0] A_RXDATA = 3'd3;
  localparam logic [REG_AW-1:0] A_TXOCC  = 3'd4;
  localparam logic [REG_AW-1:0] A_RXOCC  = 3'd5;
  localparam logic [REG_AW-1:0] A_RXTHR  = 3'd6;
  localparam logic [REG_AW-1:0] A_ERR    = 3'd7;

  // status byte bit positions
  localparam int ST_BUSY    = 2;
  localparam int ST_TXFULL  = 4;
  localparam int ST_RXFULL  = 5;
  localparam int ST_RXEMPTY = 6;
  localparam int ST_TXEMPTY = 7;

  localparam int CTL_FLUSH = 1;
  localparam int ERR_OVF   = 0;
  localparam int ERR_UNF   = 1;
endpackage

// File: rtl/iic_fs_fifo.sv
module iic_fs_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wptr, rptr;
  logic          do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full && !flush;
  assign do_pop  = pop && !empty && !flush;
  assign head    = mem[rptr];

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (do_push) wptr <= bump(wptr);
      if (do_pop)  rptr <= bump(rptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/iic_fs_regs.sv
module iic_fs_regs
  import iic_fs_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int CMD_W  = 10,
  parameter int BYTE_W = 8,
  parameter int DATA_W = 16,
  localparam int PW    = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              bus_busy,
  input  logic [CW-1:0]     tx_count,
  input  logic [CW-1:0]     rx_count,
  input  logic              tx_full,
  input  logic              tx_empty,
  input  logic              rx_full,
  input  logic              rx_empty,
  input  logic [BYTE_W-1:0] rx_head,
  output logic              tx_push,
  output logic [CMD_W-1:0]  tx_wdata,
  output logic              rx_pop,
  output logic              tx_flush,
  output logic [PW-1:0]     rx_thr,
  output logic              err_ovf,
  output logic              err_unf
);
  logic [7:0]        status;
  logic [DATA_W-1:0] rd_mux;
  logic              wr_tx, rd_rx, clr_wr;
  logic              unused_wbits;

  assign unused_wbits = ^reg_wdata;

  assign wr_tx    = reg_wr && (reg_addr == A_TXDATA);
  assign rd_rx    = reg_rd && (reg_addr == A_RXDATA);
  assign clr_wr   = reg_wr && (reg_addr == A_ERR);
  assign tx_push  = wr_tx;
  assign tx_wdata = reg_wdata[CMD_W-1:0];
  assign rx_pop   = rd_rx && !rx_empty;

  function automatic logic [PW-1:0] occ_of(input logic [CW-1:0] c);
    return (c == '0) ? '0 : PW'(c - 1'b1);
  endfunction

  always_comb begin
    status             = '0;
    status[ST_BUSY]    = bus_busy;
    status[ST_TXFULL]  = tx_full;
    status[ST_RXFULL]  = rx_full;
    status[ST_RXEMPTY] = rx_empty;
    status[ST_TXEMPTY] = tx_empty;
  end

  always_comb begin
    rd_mux = '0;
    case (reg_addr)
      A_CTRL:   rd_mux[CTL_FLUSH] = tx_flush;
      A_STATUS: rd_mux = DATA_W'(status);
      A_RXDATA: rd_mux = rx_empty ? '0 : DATA_W'(rx_head);
      A_TXOCC:  rd_mux = DATA_W'(occ_of(tx_count));
      A_RXOCC:  rd_mux = DATA_W'(occ_of(rx_count));
      A_RXTHR:  rd_mux = DATA_W'(rx_thr);
      A_ERR: begin
        rd_mux[ERR_OVF] = err_ovf;
        rd_mux[ERR_UNF] = err_unf;
      end
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
      tx_flush  <= 1'b0;
      rx_thr    <= '0;
      err_ovf   <= 1'b0;
      err_unf   <= 1'b0;
    end else begin
      if (reg_rd) reg_rdata <= rd_mux;
      if (reg_wr && reg_addr == A_CTRL)  tx_flush <= reg_wdata[CTL_FLUSH];
      if (reg_wr && reg_addr == A_RXTHR) rx_thr   <= reg_wdata[PW-1:0];
      // a new error in the same cycle wins over the clear
      if (wr_tx && tx_full && !tx_flush)            err_ovf <= 1'b1;
      else if (clr_wr && reg_wdata[ERR_OVF])        err_ovf <= 1'b0;
      if (rd_rx && rx_empty)                        err_unf <= 1'b1;
      else if (clr_wr && reg_wdata[ERR_UNF])        err_unf <= 1'b0;
    end
  end
endmodule

// File: rtl/iic_fs_events.sv
module iic_fs_events #(
  parameter int DEPTH = 16,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] tx_count,
  input  logic [CW-1:0] rx_count,
  input  logic [PW-1:0] rx_thr,
  output logic          ev_rx_level,
  output logic          ev_tx_empty,
  output logic          ev_tx_half
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ev_rx_level <= 1'b0;
      ev_tx_empty <= 1'b1;
      ev_tx_half  <= 1'b1;
    end else begin
      ev_rx_level <= (rx_count > CW'(rx_thr));
      ev_tx_empty <= (tx_count == '0);
      ev_tx_half  <= (tx_count <= CW'(DEPTH / 2));
    end
  end
endmodule

// File: rtl/iic_fifo_status.sv
module iic_fifo_status
  import iic_fs_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int CMD_W  = 10,
  parameter int BYTE_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              bus_busy,
  output logic [CMD_W-1:0]  eng_tx_word,
  output logic              eng_tx_valid,
  input  logic              eng_tx_pop,
  input  logic [BYTE_W-1:0] eng_rx_byte,
  input  logic              eng_rx_push,
  output logic              eng_rx_ready,
  output logic              ev_rx_level,
  output logic              ev_tx_empty,
  output logic              ev_tx_half
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [CW-1:0]     tx_cnt, rx_cnt;
  logic              tx_full, tx_empty, rx_full, rx_empty;
  logic              tx_push_i, rx_pop_i, tx_flush;
  logic [CMD_W-1:0]  tx_wdata;
  logic [BYTE_W-1:0] rx_head;
  logic [PW-1:0]     rx_thr;
  logic              err_ovf, err_unf;

  iic_fs_fifo #(.W(CMD_W), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst(rst), .flush(tx_flush),
    .push(tx_push_i), .wdata(tx_wdata),
    .pop(eng_tx_pop), .head(eng_tx_word),
    .count(tx_cnt), .full(tx_full), .empty(tx_empty)
  );

  iic_fs_fifo #(.W(BYTE_W), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst(rst), .flush(1'b0),
    .push(eng_rx_push), .wdata(eng_rx_byte),
    .pop(rx_pop_i), .head(rx_head),
    .count(rx_cnt), .full(rx_full), .empty(rx_empty)
  );

  iic_fs_regs #(
    .DEPTH(DEPTH), .CMD_W(CMD_W), .BYTE_W(BYTE_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk(clk), .rst(rst),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .bus_busy(bus_busy),
    .tx_count(tx_cnt), .rx_count(rx_cnt),
    .tx_full(tx_full), .tx_empty(tx_empty),
    .rx_full(rx_full), .rx_empty(rx_empty),
    .rx_head(rx_head),
    .tx_push(tx_push_i), .tx_wdata(tx_wdata), .rx_pop(rx_pop_i),
    .tx_flush(tx_flush), .rx_thr(rx_thr),
    .err_ovf(err_ovf), .err_unf(err_unf)
  );

  iic_fs_events #(.DEPTH(DEPTH)) u_ev (
    .clk(clk), .rst(rst),
    .tx_count(tx_cnt), .rx_count(rx_cnt), .rx_thr(rx_thr),
    .ev_rx_level(ev_rx_level), .ev_tx_empty(ev_tx_empty),
    .ev_tx_half(ev_tx_half)
  );

  assign eng_tx_valid = !tx_empty;
  assign eng_rx_ready = !rx_full;
endmodule

// File: rtl/iic_fifo_status_chk.sv
module iic_fifo_status_chk
  import iic_fs_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 16,
  localparam int PW    = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [REG_AW-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic              eng_tx_pop,
  input logic              eng_rx_push,
  input logic [CW-1:0]     tx_cnt,
  input logic [CW-1:0]     rx_cnt,
  input logic              tx_push_i,
  input logic              tx_flush,
  input logic [PW-1:0]     rx_thr,
  input logic              err_ovf,
  input logic              ev_rx_level,
  input logic              ev_tx_empty
);
  // R8
  flush_empties_chk: assert property (@(posedge clk) disable iff (rst)
    tx_flush |=> (tx_cnt == '0));

  // R2
  tx_pop_drains_chk: assert property (@(posedge clk) disable iff (rst)
    (eng_tx_pop && tx_cnt != '0 && !tx_push_i && !tx_flush)
    |=> (tx_cnt == $past(tx_cnt) - 1'b1));

  // R7
  tx_empty_ev_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (ev_tx_empty == ($past(tx_cnt) == '0)));

  // R6
  rx_level_ev_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (ev_rx_level == ($past(rx_cnt) > CW'($past(rx_thr)))));

  // R9
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (err_ovf && !(reg_wr && reg_addr == A_ERR && reg_wdata[ERR_OVF]))
    |=> err_ovf);

  // R10
  underflow_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr == A_RXDATA && rx_cnt == '0 && !eng_rx_push)
    |=> (rx_cnt == '0));

  // R11
  depth_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_cnt <= CW'(DEPTH)) && (rx_cnt <= CW'(DEPTH)));
endmodule

bind iic_fifo_status iic_fifo_status_chk #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/iic_fifo_status_test.sv
module iic_fifo_status_test;
  import iic_fs_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        bus_busy = 1'b0;
  logic [9:0]  eng_tx_word;
  logic        eng_tx_valid;
  logic        eng_tx_pop = 1'b0;
  logic [7:0]  eng_rx_byte = '0;
  logic        eng_rx_push = 1'b0;
  logic        eng_rx_ready;
  logic        ev_rx_level, ev_tx_empty, ev_tx_half;

  int checks = 0, errors = 0;
  bit drain_en = 1'b0;
  bit done = 1'b0;
  logic [9:0] exp_tx[$];
  logic [7:0] exp_rx[$];
  int tx_model = 0;

  always #10 clk = ~clk;

  iic_fifo_status uut (.*);

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic reg_write(logic [2:0] a, logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  // driver: transmit word, queued for the scoreboard when it fits
  task automatic tx_write(logic [9:0] w);
    if (tx_model < 16) begin
      exp_tx.push_back(w);
      tx_model++;
    end
    reg_write(A_TXDATA, {6'd0, w});
  endtask

  task automatic eng_push(logic [7:0] b);
    @(negedge clk);
    if (eng_rx_ready) exp_rx.push_back(b);
    eng_rx_push = 1'b1; eng_rx_byte = b;
    @(negedge clk);
    eng_rx_push = 1'b0;
  endtask

  task automatic rx_read_cmp();
    logic [15:0] v;
    logic [7:0]  e;
    e = exp_rx.pop_front();
    reg_read(A_RXDATA, v);
    chk("R3 rx data order", int'(v), int'(e));
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  // monitor: pops transmit words and compares with the scoreboard
  always @(negedge clk) begin
    if (eng_tx_pop) eng_tx_pop = 1'b0;
    else if (drain_en && eng_tx_valid) begin
      checks++;
      if (exp_tx.size() == 0) begin
        errors++;
        $display("FAIL R2 unexpected word actual=0x%0h expected=none", eng_tx_word);
      end else begin
        logic [9:0] e;
        e = exp_tx.pop_front();
        if (eng_tx_word !== e) begin
          errors++;
          $display("FAIL R2 tx order actual=0x%0h expected=0x%0h", eng_tx_word, e);
        end
      end
      eng_tx_pop = 1'b1;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 / R5 / R4 reset state
    reg_read(A_STATUS, v); chk("R1 status after reset", int'(v), 'hC0);
    reg_read(A_TXOCC, v);  chk("R1 tx occupancy reset", int'(v), 0);
    reg_read(A_RXOCC, v);  chk("R4 rx occupancy empty", int'(v), 0);
    chk("R1 ev_tx_empty", int'(ev_tx_empty), 1);
    chk("R1 ev_tx_half", int'(ev_tx_half), 1);
    chk("R1 ev_rx_level", int'(ev_rx_level), 0);

    // R5 busy bit
    bus_busy = 1'b1;
    reg_read(A_STATUS, v); chk("R5 busy bit 2", int'(v), 'hC4);
    bus_busy = 1'b0;

    // R4 / R7 partial fill
    tx_write(10'h155); tx_write(10'h2AA); tx_write(10'h301);
    settle();
    reg_read(A_TXOCC, v); chk("R4 tx occupancy 3 entries", int'(v), 2);
    reg_read(A_STATUS, v); chk("R5 status partial", int'(v), 'h40);
    chk("R7 ev_tx_empty clear", int'(ev_tx_empty), 0);
    chk("R7 ev_tx_half at 3", int'(ev_tx_half), 1);

    // R7 half boundary
    for (int i = 3; i < 8; i++) tx_write(10'(i * 37));
    settle();
    chk("R7 ev_tx_half at 8", int'(ev_tx_half), 1);
    tx_write(10'h0F0);
    settle();
    chk("R7 ev_tx_half at 9", int'(ev_tx_half), 0);

    // R11 full
    for (int i = 9; i < 16; i++) tx_write(10'(i * 51 + 3));
    settle();
    reg_read(A_TXOCC, v); chk("R11 tx occupancy full", int'(v), 15);
    reg_read(A_STATUS, v); chk("R11 tx full bit 4", int'(v), 'h50);

    // R9 overflow
    tx_write(10'h3FF);
    reg_read(A_TXOCC, v); chk("R9 occupancy unchanged", int'(v), 15);
    reg_read(A_ERR, v); chk("R9 overflow flag", int'(v), 1);
    reg_read(A_ERR, v); chk("R9 overflow sticky", int'(v), 1);
    reg_write(A_ERR, 16'h0001);
    reg_read(A_ERR, v); chk("R9 overflow cleared", int'(v), 0);

    // R2 drain through the scoreboard monitor
    drain_en = 1'b1;
    wait (exp_tx.size() == 0);
    repeat (3) @(negedge clk);
    drain_en = 1'b0;
    tx_model = 0;
    chk("R2 valid low after drain", int'(eng_tx_valid), 0);
    chk("R7 ev_tx_empty after drain", int'(ev_tx_empty), 1);

    // R8 flush
    for (int i = 0; i < 5; i++) tx_write(10'(i + 100));
    reg_write(A_CTRL, 16'h0002);
    reg_write(A_CTRL, 16'h0000);
    exp_tx.delete(); tx_model = 0;
    settle();
    reg_read(A_TXOCC, v); chk("R8 flush occupancy", int'(v), 0);
    reg_read(A_STATUS, v); chk("R8 flush status empty", int'(v), 'hC0);
    chk("R8 flush valid low", int'(eng_tx_valid), 0);
    chk("R8 flush ev_tx_empty", int'(ev_tx_empty), 1);

    // R6 threshold 3 -> 4 bytes
    reg_write(A_RXTHR, 16'd3);
    for (int i = 0; i < 3; i++) eng_push(8'(8'hA0 + i));
    settle();
    chk("R6 below threshold", int'(ev_rx_level), 0);
    eng_push(8'hA3);
    settle();
    chk("R6 at threshold", int'(ev_rx_level), 1);
    reg_read(A_RXOCC, v); chk("R4 rx occupancy 4", int'(v), 3);
    rx_read_cmp();
    settle();
    chk("R6 drops after pop", int'(ev_rx_level), 0);
    reg_read(A_RXOCC, v); chk("R3 one pop per read", int'(v), 2);

    // R11 receive full
    for (int i = 0; i < 13; i++) eng_push(8'(i * 19 + 1));
    settle();
    reg_read(A_STATUS, v); chk("R11 rx full bit 5", int'(v), 'hA0);
    chk("R11 rx ready low", int'(eng_rx_ready), 0);
    eng_push(8'hEE);
    reg_read(A_RXOCC, v); chk("R11 push to full dropped", int'(v), 15);
    while (exp_rx.size() > 0) rx_read_cmp();

    // R10 underflow
    reg_read(A_RXDATA, v); chk("R10 empty read data", int'(v), 0);
    reg_read(A_RXOCC, v);  chk("R10 occupancy unchanged", int'(v), 0);
    reg_read(A_ERR, v);    chk("R10 underflow flag", int'(v), 2);
    reg_write(A_ERR, 16'h0002);
    reg_read(A_ERR, v);    chk("R10 underflow cleared", int'(v), 0);

    // R6 zero threshold
    reg_write(A_RXTHR, 16'd0);
    eng_push(8'h5A);
    settle();
    chk("R6 threshold 0 one byte", int'(ev_rx_level), 1);
    rx_read_cmp();

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule